// File: doc/BRIEF.md
# Calendar Real-Time Counter with Alarm

This block keeps wall-clock time as one packed 32-bit word holding year, month, day, hour, minute and second in 24-hour form. A tick-enable input, nominally 1 kHz, feeds a power-of-two prescaler. Each time the prescaler completes a period, the calendar steps forward by one second. The carries run through minutes, hours and days, where the day limit depends on the month and on a leap rule. They continue through months and into a 6-bit year offset. When the year offset wraps, an overflow flag is raised.

A single alarm word is compared against the calendar. A mask selector chooses how many fields take part, starting from the seconds. The alarm and overflow flags are cleared by writing one to them. Each flag has an enable, and the enables are changed through separate set and clear registers. The interrupt output is the OR of every enabled flag.

Software uses a plain synchronous register port with a registered read path. A write to the control, clock or alarm register is held for a short settling window, during which a busy bit is set. A software-reset bit returns every register to its default value.

Top module: `cal_rtc`

## Requirements
- R1: While enabled, the calendar advances by one second once every 2^N accepted ticks, where N is control bits [5:2] and resets to 10, so the default period is 1024 ticks. Applying a clock write restarts the prescaler count.
- R2: The year field is bits [31:26] and counts from 0 to 63. A carry out of year 63 gives year 0 and sets the overflow flag, which is flag bit 1.
- R3: The clock word has second in [5:0], minute in [11:6], hour in [16:12], day in [21:17] and month in [25:22]. Seconds and minutes wrap at 60 and hours wrap at 24. The day returns to 1 after 30 in months 4, 6, 9 and 11. In month 2 it returns to 1 after 29 when the year is divisible by 4, and after 28 otherwise. In every other month it returns to 1 after 31. The month returns to 1 after 12.
- R4: The alarm selector is bits [2:0] at address 3. Value 0 disables the alarm. A value k from 1 to 5 compares the k lowest fields, counting up from seconds. Values 6 and 7 compare all six fields. Alarm flag bit 0 is set on the one-second step that makes the clock match the compared fields.
- R5: The flag register is at address 6. Writing 1 to a bit clears that flag, and writing 0 to it leaves the flag unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R6: Writing 1 to a bit at address 4 sets that interrupt enable, and writing 1 to a bit at address 5 clears it. Both addresses read back the current enables. `irq` equals the OR over both bits of flag AND enable, and is in step with the flags as they read back.
- R7: Writing control bit 1 to 1 performs a software reset. In the next cycle every register returns to its default: clock year 0, month 1, day 1, time 00:00:00; alarm and selector 0; enables and flags 0; control disabled with prescaler exponent 10. The reset bit then clears itself.
- R8: A write to control (address 0), clock (address 1) or alarm (address 2) sets the busy bit, which is status bit 0 at address 7. The busy bit stays high for SYNC_LAT cycles. The new value takes effect on the edge where busy drops. Writes to these three registers are ignored while busy is high.
- R9: While control bit 0 (enable) is 0, neither the prescaler nor the calendar changes.
- R10: `bus_rdata` is registered. One cycle after an address is presented, it shows the register at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base tick enable (nominally 1 kHz) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt: OR of enabled flags |

## Verification
Faults in the carry chain stay hidden until a boundary is crossed. A wrong month-length rule or a missing leap case shows up only on the step out of the last day of a month, and then as a wrong day or month in the clock word. The bench therefore loads clocks close to each boundary and reads them back after one second. An error in the alarm prefix shows as a flag that is missing or spurious on the step where the compared fields first match. A busy or staging fault shows within two or three cycles of a write, as a new value that appears early, late, or after it should have been dropped.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

  typedef struct packed {
    logic [5:0] year;
    logic [3:0] month;
    logic [4:0] day;
    logic [4:0] hour;
    logic [5:0] minute;
    logic [5:0] second;
  } cal_t;

  localparam int WORD_W = $bits(cal_t);
  localparam int NFIELD = 6;

  localparam cal_t CAL_DEFAULT = '{year: 6'd0, month: 4'd1, day: 5'd1,
                                   hour: 5'd0, minute: 6'd0, second: 6'd0};

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_CLOCK  = 3'd1;
  localparam logic [2:0] A_ALARM  = 3'd2;
  localparam logic [2:0] A_MASK   = 3'd3;
  localparam logic [2:0] A_IESET  = 3'd4;
  localparam logic [2:0] A_IECLR  = 3'd5;
  localparam logic [2:0] A_FLAG   = 3'd6;
  localparam logic [2:0] A_STATUS = 3'd7;

  function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [5:0] yr);
    case (mon)
      4'd2:                    month_len = (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: month_len = 5'd30;
      default:                 month_len = 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/cal_rtc_presc.sv
module cal_rtc_presc #(
  parameter int LOG2_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              run,
  input  logic              tick,
  input  logic [LOG2_W-1:0] log2_div,
  output logic              step
);
  localparam int CNT_W = 2 ** LOG2_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last = CNT_W'((33'd1 << log2_div) - 33'd1);
  assign step = run && tick && (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt_q <= '0;
    else if (run && tick)  cnt_q <= step ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/cal_rtc_calendar.sv
module cal_rtc_calendar
  import cal_rtc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  cal_t load_val,
  input  logic step,
  output cal_t cal_q,
  output cal_t cal_nxt,
  output logic wrap
);
  logic carry_y;

  always_comb begin
    cal_nxt = cal_q;
    carry_y = 1'b0;
    if (cal_q.second >= 6'd59) begin
      cal_nxt.second = '0;
      if (cal_q.minute >= 6'd59) begin
        cal_nxt.minute = '0;
        if (cal_q.hour >= 5'd23) begin
          cal_nxt.hour = '0;
          if (cal_q.day >= month_len(cal_q.month, cal_q.year)) begin
            cal_nxt.day = 5'd1;
            if (cal_q.month >= 4'd12) begin
              cal_nxt.month = 4'd1;
              cal_nxt.year  = cal_q.year + 6'd1;
              carry_y       = (cal_q.year == 6'd63);
            end else begin
              cal_nxt.month = cal_q.month + 4'd1;
            end
          end else begin
            cal_nxt.day = cal_q.day + 5'd1;
          end
        end else begin
          cal_nxt.hour = cal_q.hour + 5'd1;
        end
      end else begin
        cal_nxt.minute = cal_q.minute + 6'd1;
      end
    end else begin
      cal_nxt.second = cal_q.second + 6'd1;
    end
  end

  assign wrap = step && !load && carry_y;

  always_ff @(posedge clk) begin
    if (rst)       cal_q <= CAL_DEFAULT;
    else if (load) cal_q <= load_val;
    else if (step) cal_q <= cal_nxt;
  end
endmodule

// File: rtl/cal_rtc_match.sv
module cal_rtc_match
  import cal_rtc_pkg::*;
(
  input  cal_t       cur,
  input  cal_t       alm,
  input  logic [2:0] sel,
  output logic       hit
);
  logic [NFIELD-1:0] eq;
  logic [NFIELD-1:0] need;

  assign eq = {cur.year == alm.year, cur.month == alm.month, cur.day == alm.day,
               cur.hour == alm.hour, cur.minute == alm.minute, cur.second == alm.second};

  for (genvar i = 0; i < NFIELD; i++) begin : g_need
    assign need[i] = (32'(sel) > i);
  end

  assign hit = (sel != 3'd0) && (&(eq | ~need));
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int LOG2_W   = 4,
  parameter int DEF_LOG2 = 10,
  parameter int SYNC_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int BW = $clog2(SYNC_LAT + 1);

  logic              swrst_q, soft_rst;
  logic              en_q;
  logic [LOG2_W-1:0] log2_q;
  cal_t              alm_q;
  logic [2:0]        sel_q;
  logic [1:0]        ie_q, ie_d, fl_q, fl_d;
  logic              busy_q;
  logic [BW-1:0]     bcnt_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [WORD_W-1:0] pend_data_q;
  logic              sync_wr, swrst_wr, apply, cal_load;
  logic              step, wrap, cmp_hit, alm_set;
  cal_t              cal_q, cal_nxt;

  assign soft_rst = rst || swrst_q;
  assign swrst_wr = bus_we && (bus_addr == A_CTRL) && bus_wdata[1];
  assign sync_wr  = bus_we && !busy_q && !swrst_wr &&
                    ((bus_addr == A_CTRL) || (bus_addr == A_CLOCK) || (bus_addr == A_ALARM));
  assign apply    = busy_q && (bcnt_q == BW'(1));
  assign cal_load = apply && (pend_addr_q == A_CLOCK);

  cal_rtc_presc #(.LOG2_W(LOG2_W)) presc_i (
    .clk(clk), .rst(soft_rst), .clr(cal_load), .run(en_q), .tick(tick),
    .log2_div(log2_q), .step(step)
  );

  cal_rtc_calendar cal_i (
    .clk(clk), .rst(soft_rst), .load(cal_load), .load_val(cal_t'(pend_data_q)),
    .step(step), .cal_q(cal_q), .cal_nxt(cal_nxt), .wrap(wrap)
  );

  cal_rtc_match match_i (.cur(cal_nxt), .alm(alm_q), .sel(sel_q), .hit(cmp_hit));

  assign alm_set = step && !cal_load && cmp_hit;

  always_comb begin
    ie_d = ie_q;
    fl_d = fl_q;
    if (bus_we && bus_addr == A_IESET) ie_d = ie_d | bus_wdata[1:0];
    if (bus_we && bus_addr == A_IECLR) ie_d = ie_d & ~bus_wdata[1:0];
    if (bus_we && bus_addr == A_FLAG)  fl_d = fl_d & ~bus_wdata[1:0];
    if (alm_set) fl_d[0] = 1'b1;
    if (wrap)    fl_d[1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           swrst_q <= 1'b0;
    else if (swrst_q)  swrst_q <= 1'b0;
    else if (swrst_wr) swrst_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (soft_rst) begin
      en_q        <= 1'b0;
      log2_q      <= LOG2_W'(DEF_LOG2);
      alm_q       <= '0;
      sel_q       <= '0;
      ie_q        <= '0;
      fl_q        <= '0;
      busy_q      <= 1'b0;
      bcnt_q      <= '0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      irq         <= 1'b0;
    end else begin
      ie_q <= ie_d;
      fl_q <= fl_d;
      irq  <= |(fl_d & ie_d);
      if (bus_we && bus_addr == A_MASK) sel_q <= bus_wdata[2:0];
      if (sync_wr) begin
        busy_q      <= 1'b1;
        bcnt_q      <= BW'(SYNC_LAT);
        pend_addr_q <= bus_addr;
        pend_data_q <= bus_wdata;
      end else if (busy_q) begin
        if (apply) begin
          busy_q <= 1'b0;
          if (pend_addr_q == A_CTRL) begin
            en_q   <= pend_data_q[0];
            log2_q <= pend_data_q[2 +: LOG2_W];
          end
          if (pend_addr_q == A_ALARM) alm_q <= cal_t'(pend_data_q);
        end
        bcnt_q <= bcnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        A_CTRL:            bus_rdata <= WORD_W'({log2_q, swrst_q, en_q});
        A_CLOCK:           bus_rdata <= cal_q;
        A_ALARM:           bus_rdata <= alm_q;
        A_MASK:            bus_rdata <= WORD_W'(sel_q);
        A_IESET, A_IECLR:  bus_rdata <= WORD_W'(ie_q);
        A_FLAG:            bus_rdata <= WORD_W'(fl_q);
        default:           bus_rdata <= WORD_W'(busy_q);
      endcase
    end
  end
endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic [1:0]  wd_lo,
  input logic        busy,
  input logic        en,
  input logic [31:0] cal,
  input logic [1:0]  fl,
  input logic [1:0]  ie,
  input logic        swrst,
  input logic        alm_set
);
  // R8
  busy_set_chk: assert property (@(posedge clk) disable iff (rst)
    bus_we && bus_addr == 3'd1 && !busy && !swrst |=> busy);

  // R2
  ovf_year_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fl[1]) |-> cal[31:26] == 6'd0);

  // R5
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    bus_we && bus_addr == 3'd6 && wd_lo[0] && !alm_set && !swrst |=> !fl[0]);

  // R6
  ie_set_chk: assert property (@(posedge clk) disable iff (rst)
    bus_we && bus_addr == 3'd4 && wd_lo[1] && !swrst |=> ie[1]);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en && !busy && !swrst |=> $stable(cal));

  // R7
  swrst_chk: assert property (@(posedge clk) disable iff (rst)
    swrst |=> !en && cal == 32'h0042_0000 && fl == 2'b00 && !swrst);
endmodule

bind cal_rtc cal_rtc_chk chk_i (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .wd_lo(bus_wdata[1:0]), .busy(busy_q), .en(en_q), .cal(cal_q),
  .fl(fl_q), .ie(ie_q), .swrst(swrst_q), .alm_set(alm_set)
);

// File: tb/cal_rtc_tb_top.sv
module cal_rtc_tb_top;
  localparam logic [2:0] R_CTRL = 3'd0, R_CLK = 3'd1, R_ALM = 3'd2, R_MASK = 3'd3;
  localparam logic [2:0] R_IES = 3'd4, R_IEC = 3'd5, R_FLG = 3'd6, R_STA = 3'd7;
  localparam logic [31:0] DEF_CLK = 32'h0042_0000;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq;

  int compared = 0, mismatched = 0, cycles = 0;
  logic [31:0] m_cal, m_alm;
  logic [2:0]  m_sel;
  logic [1:0]  m_fl, m_ie;

  always #10 clk = ~clk;

  cal_rtc dut_i (.clk(clk), .rst(rst), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
                 .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 190000)", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: act %h exp %h", req, what, act, exp);
    end
  endtask

  function automatic int b_dim(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] b_pack(int y, int mo, int d, int h, int mi, int s);
    return {6'(y), 4'(mo), 5'(d), 5'(h), 6'(mi), 6'(s)};
  endfunction

  function automatic logic [32:0] b_inc(logic [31:0] c);
    int s = c[5:0], mi = c[11:6], h = c[16:12], d = c[21:17], mo = c[25:22], y = c[31:26];
    logic w = 1'b0;
    s++;
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h++;
        if (h == 24) begin
          h = 0; d++;
          if (d > b_dim(mo, y)) begin
            d = 1; mo++;
            if (mo == 13) begin
              mo = 1; y++;
              if (y == 64) begin y = 0; w = 1'b1; end
            end
          end
        end
      end
    end
    return {w, b_pack(y, mo, d, h, mi, s)};
  endfunction

  function automatic logic [31:0] b_field(logic [31:0] v, int i);
    case (i)
      0: return 32'(v[5:0]);
      1: return 32'(v[11:6]);
      2: return 32'(v[16:12]);
      3: return 32'(v[21:17]);
      4: return 32'(v[25:22]);
      default: return 32'(v[31:26]);
    endcase
  endfunction

  function automatic logic b_match(logic [31:0] cur, logic [31:0] alm, logic [2:0] sel);
    int n = (sel > 6) ? 6 : int'(sel);
    if (n == 0) return 1'b0;
    for (int i = 0; i < n; i++) if (b_field(cur, i) != b_field(alm, i)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [31:0] b_rand_cal();
    int y = $urandom_range(63), mo = $urandom_range(12, 1);
    return b_pack(y, mo, $urandom_range(b_dim(mo, y), 1), $urandom_range(23),
                  $urandom_range(59), $urandom_range(59));
  endfunction

  // all tasks start and end at a falling edge
  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    logic [31:0] s;
    for (int i = 0; i < 8; i++) begin
      rd(R_STA, s);
      if (!s[0]) break;
    end
  endtask

  task automatic wr_sync(logic [2:0] a, logic [31:0] d);
    wr(a, d);
    settle();
  endtask

  task automatic ticks(int n, bit model);
    logic [32:0] r;
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      if (model) begin
        r = b_inc(m_cal);
        if (b_match(r[31:0], m_alm, m_sel)) m_fl[0] = 1'b1;
        if (r[32]) m_fl[1] = 1'b1;
        m_cal = r[31:0];
      end
    end
    tick = 1'b0;
  endtask

  task automatic load_clock(logic [31:0] v);
    wr_sync(R_CLK, v);
    m_cal = v;
  endtask

  task automatic check_state(string req);
    logic [31:0] v;
    rd(R_CLK, v); chk(req, "clock", v, m_cal);
    rd(R_FLG, v); chk(req, "flags", v, 32'(m_fl));
    chk("R6", "irq", 32'(irq), 32'(|(m_fl & m_ie)));
  endtask

  initial begin
    logic [31:0] v, a;
    logic [32:0] r;
    int k;
    void'($urandom(32'd20240607));
    m_alm = '0; m_sel = '0; m_fl = '0; m_ie = '0; m_cal = DEF_CLK;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset values through registered read path
    rd(R_CLK, v);  chk("R10", "reset clock", v, DEF_CLK);
    rd(R_CTRL, v); chk("R10", "reset ctrl", v, 32'h28);
    chk("R6", "reset irq", 32'(irq), 0);

    // R8 busy window, staged value, ignored second write
    wr(R_CLK, b_pack(3, 5, 7, 8, 9, 10));
    rd(R_CLK, v); chk("R8", "old value during busy", v, DEF_CLK);
    rd(R_STA, v); chk("R8", "busy high", v, 1);
    rd(R_STA, v); chk("R8", "busy dropped", v, 0);
    rd(R_CLK, v); chk("R8", "applied value", v, b_pack(3, 5, 7, 8, 9, 10));
    wr(R_CLK, b_pack(1, 1, 1, 1, 1, 1));
    wr(R_CLK, b_pack(2, 2, 2, 2, 2, 2));
    settle();
    rd(R_CLK, v); chk("R8", "write during busy ignored", v, b_pack(1, 1, 1, 1, 1, 1));
    m_cal = v;

    // R9 disabled counter holds
    ticks(40, 0);
    rd(R_CLK, v); chk("R9", "hold while disabled", v, m_cal);

    // R1 default prescaler of 1024
    wr_sync(R_CTRL, 32'h29);
    load_clock(DEF_CLK);
    ticks(1023, 0);
    rd(R_CLK, v); chk("R1", "no step before 1024 ticks", v, DEF_CLK);
    ticks(1, 0);
    rd(R_CLK, v); chk("R1", "step at tick 1024", v, DEF_CLK + 1);

    // divide by 1 for the rest
    wr_sync(R_CTRL, 32'h01);

    // R3 / R2 carry boundaries
    load_clock(b_pack(9, 3, 4, 5, 6, 59));  ticks(1, 1); check_state("R3");
    load_clock(b_pack(5, 4, 30, 23, 59, 59)); ticks(1, 1); check_state("R3");
    chk("R3", "apr30 -> may1", m_cal, b_pack(5, 5, 1, 0, 0, 0));
    load_clock(b_pack(1, 2, 28, 23, 59, 59)); ticks(1, 1); check_state("R3");
    chk("R3", "feb28 y1 -> mar1", m_cal, b_pack(1, 3, 1, 0, 0, 0));
    load_clock(b_pack(4, 2, 28, 23, 59, 59)); ticks(1, 1); check_state("R3");
    chk("R3", "feb28 y4 -> feb29", m_cal, b_pack(4, 2, 29, 0, 0, 0));
    load_clock(b_pack(4, 2, 29, 23, 59, 59)); ticks(1, 1); check_state("R3");
    load_clock(b_pack(10, 12, 31, 23, 59, 59)); ticks(1, 1); check_state("R3");
    load_clock(b_pack(63, 12, 31, 23, 59, 59)); ticks(1, 1); check_state("R2");
    chk("R2", "year wrap", m_cal, DEF_CLK);
    chk("R2", "ovf model", 32'(m_fl), 2);

    // R6 enable set/clear and irq
    wr(R_IES, 32'h2); m_ie = 2'b10;
    rd(R_IES, v); chk("R6", "ie set", v, 2);
    chk("R6", "irq from ovf", 32'(irq), 1);
    wr(R_IEC, 32'h2); m_ie = 2'b00;
    rd(R_IEC, v); chk("R6", "ie clear", v, 0);
    chk("R6", "irq off", 32'(irq), 0);

    // R5 write-one-to-clear
    wr(R_FLG, 32'h0);
    rd(R_FLG, v); chk("R5", "zero write no effect", v, 2);
    wr(R_FLG, 32'h2); m_fl = 2'b00;
    rd(R_FLG, v); chk("R5", "one clears", v, 0);

    // R4 alarm levels, directed then random
    for (int lvl = 0; lvl < 8; lvl++) begin
      load_clock(b_rand_cal());
      k = $urandom_range(200, 1);
      a = m_cal;
      for (int i = 0; i < k; i++) begin r = b_inc(a); a = r[31:0]; end
      m_alm = a; m_sel = 3'(lvl);
      wr_sync(R_ALM, m_alm);
      wr(R_MASK, 32'(m_sel));
      wr(R_FLG, 32'h3); m_fl = 2'b00;
      m_ie = 2'($urandom_range(3));
      wr(R_IES, 32'(m_ie)); wr(R_IEC, 32'(~m_ie));
      ticks(k, 1);
      check_state("R4");
      chk("R4", "alarm at level", 32'(m_fl[0]), 32'(lvl != 0));
    end

    for (int n = 0; n < 25; n++) begin
      load_clock(b_rand_cal());
      m_alm = ($urandom_range(1)) ? b_rand_cal() : m_cal + 32'($urandom_range(60, 1));
      m_sel = 3'($urandom_range(7));
      wr_sync(R_ALM, m_alm);
      wr(R_MASK, 32'(m_sel));
      m_ie = 2'($urandom_range(3));
      wr(R_IES, 32'(m_ie)); wr(R_IEC, 32'(~m_ie));
      ticks($urandom_range(3000, 1), 1);
      check_state("R3");
      wr(R_FLG, 32'(m_fl)); m_fl = 2'b00;
    end

    // R7 software reset
    wr(R_IES, 32'h3);
    wr(R_CTRL, 32'h2);
    rd(R_CTRL, v); chk("R7", "reset bit visible", v[1], 1);
    rd(R_CTRL, v); chk("R7", "ctrl default", v, 32'h28);
    rd(R_CLK, v);  chk("R7", "clock default", v, DEF_CLK);
    rd(R_ALM, v);  chk("R7", "alarm default", v, 0);
    rd(R_MASK, v); chk("R7", "mask default", v, 0);
    rd(R_IES, v);  chk("R7", "enables default", v, 0);
    rd(R_FLG, v);  chk("R7", "flags default", v, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule